// File: doc/BRIEF.md
# Snoop Inquiry Responder

This unit answers external inquiry cycles on behalf of a small cache. When the system raises the snoop strobe, the unit takes the line address and its parity bit. It reads the line's tag and coherence state from a small direct-mapped array. Two clocks later it reports the outcome on three outputs: hit, hit-on-modified, and address-parity-error.

A hit changes the line's coherence state. The invalidate input chooses between shared and invalid. A hit on a modified line also keeps hit-on-modified raised and runs a four-beat burst writeback. The writeback starts at a time that depends on how the system took the bus:

- **Address-hold:** a fixed delay after the report.
- **Back-off or bus-hold:** the first cycle after the grant-holding input is sampled low.

Only one bus cycle runs at a time. Strobes that arrive while a lookup or writeback is busy are dropped, except on the final burst-ready. A fill port lets the cache side install lines. A registered address-bus drive enable follows the address-hold input.

Top module: `snoop_responder`

## Requirements
- R1: After reset, `hit`, `hitm`, `apchk` and `wb_active` are low and `addr_oe` is high.
- R2: A strobe sampled on a clock edge captures `snp_line`. `hit`, `hitm` and `apchk` for that inquiry show on the second edge after it. `hit` and `apchk` are one-cycle pulses.
- R3: Line states are encoded invalid=00, shared=01, exclusive=10, modified=11. The low `IDX_W` bits of a line address select the entry and the rest is the tag. A hit needs a tag match and a state other than invalid. A miss leaves the entry unchanged.
- R4: A hit while `snp_inv` is low leaves the line shared, whether it was exclusive, modified or shared.
- R5: A hit while `snp_inv` is high leaves the line invalid. If the line was modified, the writeback still runs first.
- R6: A hit on a modified line raises `hitm` together with `hit`. `hitm` stays high until the fourth `burst_rdy` of the writeback. During the writeback `wb_line` shows the snooped line and `wb_beat` counts 0 to 3, advancing only on `burst_rdy`.
- R7: With `acq_mode`=00 (address-hold), `wb_active` rises two clocks after `hitm` rises, whatever `bus_held` does.
- R8: With `acq_mode`=01 (back-off) or 10 (bus-hold), `wb_active` rises on the clock after `bus_held` is first sampled low once `hitm` is up.
- R9: A strobe sampled during a lookup, during the writeback wait, or on any writeback beat but the last gets no response and changes no line state.
- R10: A strobe sampled together with the final `burst_rdy` is accepted as a new inquiry.
- R11: `snp_par` must equal the XOR of all `snp_line` bits. On a mismatch, `apchk` pulses two clocks after the strobe. In that case `hit` and `hitm` stay low, no writeback starts and the line state is kept.
- R12: `addr_oe` goes low one clock after `addr_hold` goes high and returns high one clock after it drops.
- R13: A `fill_we` cycle writes `fill_state` and the tag of `fill_line` into the selected entry, and the next inquiry sees them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| snp_strobe | input | 1 | Inquiry address strobe |
| snp_line | input | LADDR_W | Inquiry line address (address bits 31..5) |
| snp_par | input | 1 | Even parity bit for `snp_line` |
| snp_inv | input | 1 | Invalidate request for the inquiry |
| acq_mode | input | 2 | How the bus was taken: 00 address-hold, 01 back-off, 10 bus-hold |
| bus_held | input | 1 | Back-off or hold-acknowledge still active |
| addr_hold | input | 1 | Address-hold request from the system |
| burst_rdy | input | 1 | Beat acknowledge for the writeback |
| fill_we | input | 1 | Install a line |
| fill_line | input | LADDR_W | Line address to install |
| fill_state | input | 2 | Coherence state to install |
| hit | output | 1 | Inquiry hit |
| hitm | output | 1 | Inquiry hit on a modified line, held through the writeback |
| apchk | output | 1 | Inquiry address parity error |
| wb_active | output | 1 | Writeback burst in progress |
| wb_line | output | LADDR_W | Line address being written back |
| wb_beat | output | BEAT_W | Current writeback beat |
| addr_oe | output | 1 | Address bus drive enable |

## Verification
Two functions can meet on one clock edge: a writeback finishing on its last `burst_rdy`, and a new inquiry being accepted. The bench provokes this by raising the strobe together with the fourth beat acknowledge on a shared line. It then expects `wb_active` and `hitm` to drop on the next cycle and a hit pulse two clocks after that edge. A stray strobe placed in the writeback wait window, and another placed in the lookup cycle, must instead leave no response in the scoreboard and leave the line state as it was.

// File: rtl/snp_pkg.sv
package snp_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } mesi_t;

  typedef enum logic [1:0] {
    ACQ_AHOLD = 2'b00,
    ACQ_BOFF  = 2'b01,
    ACQ_HOLD  = 2'b10,
    ACQ_RSVD  = 2'b11
  } acq_t;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_LOOK,
    SQ_WAIT,
    SQ_BURST
  } seq_t;
endpackage

// File: rtl/snp_tag_array.sv
module snp_tag_array
  import snp_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int TAG_W = 24,
  localparam int DEPTH = 1 << IDX_W,
  localparam int ENT_W = TAG_W + 2
) (
  input  logic             clk,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output mesi_t            rd_st,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  mesi_t            wr_st
);
  logic [ENT_W-1:0] mem [DEPTH];
  logic [ENT_W-1:0] rd_q;

  // one write port, one registered read port
  always_ff @(posedge clk) begin
    if (we) mem[wr_idx] <= {wr_tag, wr_st};
    if (rd_en) rd_q <= mem[rd_idx];
  end

  assign rd_tag = rd_q[ENT_W-1:2];
  assign rd_st  = mesi_t'(rd_q[1:0]);
endmodule

// File: rtl/snp_eval.sv
module snp_eval
  import snp_pkg::*;
#(
  parameter int LADDR_W = 27,
  parameter int IDX_W   = 3,
  localparam int TAG_W  = LADDR_W - IDX_W
) (
  input  logic [LADDR_W-1:0] line_q,
  input  logic               par_q,
  input  logic               inv_q,
  input  logic [TAG_W-1:0]   rd_tag,
  input  mesi_t              rd_st,
  output logic               par_err,
  output logic               hit,
  output logic               modified,
  output mesi_t              nxt_st
);
  logic tag_eq;

  always_comb begin
    par_err  = (^line_q) != par_q;
    tag_eq   = rd_tag == line_q[LADDR_W-1:IDX_W];
    hit      = tag_eq && (rd_st != ST_I) && !par_err;
    modified = hit && (rd_st == ST_M);
    nxt_st   = inv_q ? ST_I : ST_S;
  end
endmodule

// File: rtl/snp_seq.sv
module snp_seq
  import snp_pkg::*;
#(
  parameter int BEATS    = 4,
  parameter int AH_DELAY = 2,
  localparam int BEAT_W  = $clog2(BEATS),
  localparam int CNT_W   = $clog2(AH_DELAY + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  acq_t              mode,
  input  logic              bus_held,
  input  logic              burst_rdy,
  input  logic              hit,
  input  logic              modified,
  input  logic              par_err,
  output logic              accept,
  output logic              upd_we,
  output logic              hit_o,
  output logic              hitm_o,
  output logic              apchk_o,
  output logic              wb_active,
  output logic [BEAT_W-1:0] wb_beat
);
  seq_t             st;
  logic [CNT_W-1:0] cnt;
  logic             last_beat;

  assign last_beat = wb_beat == BEAT_W'(BEATS - 1);
  assign accept    = strobe && ((st == SQ_IDLE) ||
                     (st == SQ_BURST && burst_rdy && last_beat));
  assign upd_we    = (st == SQ_LOOK) && hit;
  assign wb_active = st == SQ_BURST;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SQ_IDLE;
      hit_o   <= 1'b0;
      hitm_o  <= 1'b0;
      apchk_o <= 1'b0;
      wb_beat <= '0;
      cnt     <= '0;
    end else begin
      hit_o   <= 1'b0;
      apchk_o <= 1'b0;
      case (st)
        SQ_IDLE: if (accept) st <= SQ_LOOK;
        SQ_LOOK: begin
          hit_o   <= hit;
          apchk_o <= par_err;
          if (modified) begin
            hitm_o  <= 1'b1;
            cnt     <= '0;
            wb_beat <= '0;
            st      <= SQ_WAIT;
          end else begin
            st <= SQ_IDLE;
          end
        end
        SQ_WAIT: begin
          if (mode == ACQ_AHOLD) begin
            if (cnt == CNT_W'(AH_DELAY - 1)) st <= SQ_BURST;
            else cnt <= cnt + 1'b1;
          end else if (!bus_held) begin
            st <= SQ_BURST;
          end
        end
        SQ_BURST: begin
          if (burst_rdy) begin
            if (last_beat) begin
              hitm_o <= 1'b0;
              st     <= accept ? SQ_LOOK : SQ_IDLE;
            end else begin
              wb_beat <= wb_beat + 1'b1;
            end
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assert_resp_timing_R2: assert property (@(posedge clk) disable iff (rst)
    (hit_o || apchk_o) |-> $past(strobe, 2));
  assert_hitm_with_hit_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(hitm_o) |-> hit_o);
  assert_wb_under_hitm_R6: assert property (@(posedge clk) disable iff (rst)
    wb_active |-> hitm_o);
  assert_beat_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (wb_active && !burst_rdy) |=> $stable(wb_beat));
  assert_perr_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    apchk_o |-> (!hit_o && !$rose(hitm_o)));
  assert_ahold_launch_R7: assert property (@(posedge clk) disable iff (rst)
    ($rose(wb_active) && mode == ACQ_AHOLD) |-> ($past(hitm_o) && !$past(hit_o)));
  assert_hold_launch_R8: assert property (@(posedge clk) disable iff (rst)
    ($rose(wb_active) && mode != ACQ_AHOLD) |-> !$past(bus_held));
endmodule

// File: rtl/snoop_responder.sv
module snoop_responder
  import snp_pkg::*;
#(
  parameter int LADDR_W  = 27,
  parameter int IDX_W    = 3,
  parameter int BEATS    = 4,
  parameter int AH_DELAY = 2,
  localparam int TAG_W   = LADDR_W - IDX_W,
  localparam int BEAT_W  = $clog2(BEATS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               snp_strobe,
  input  logic [LADDR_W-1:0] snp_line,
  input  logic               snp_par,
  input  logic               snp_inv,
  input  logic [1:0]         acq_mode,
  input  logic               bus_held,
  input  logic               addr_hold,
  input  logic               burst_rdy,
  input  logic               fill_we,
  input  logic [LADDR_W-1:0] fill_line,
  input  logic [1:0]         fill_state,
  output logic               hit,
  output logic               hitm,
  output logic               apchk,
  output logic               wb_active,
  output logic [LADDR_W-1:0] wb_line,
  output logic [BEAT_W-1:0]  wb_beat,
  output logic               addr_oe
);
  logic [LADDR_W-1:0] line_q;
  logic               par_q, inv_q;
  acq_t               mode_q;
  logic               accept, upd_we;
  logic [TAG_W-1:0]   rd_tag;
  mesi_t              rd_st, nxt_st;
  logic               lk_hit, lk_mod, lk_perr;
  logic               we;
  logic [IDX_W-1:0]   wr_idx;
  logic [TAG_W-1:0]   wr_tag;
  mesi_t              wr_st;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q  <= '0;
      par_q   <= 1'b0;
      inv_q   <= 1'b0;
      mode_q  <= ACQ_AHOLD;
      addr_oe <= 1'b1;
    end else begin
      addr_oe <= !addr_hold;
      if (accept) begin
        line_q <= snp_line;
        par_q  <= snp_par;
        inv_q  <= snp_inv;
        mode_q <= acq_t'(acq_mode);
      end
    end
  end

  // the snoop update wins over a fill in the same cycle
  always_comb begin
    we     = upd_we || fill_we;
    wr_idx = upd_we ? line_q[IDX_W-1:0] : fill_line[IDX_W-1:0];
    wr_tag = upd_we ? line_q[LADDR_W-1:IDX_W] : fill_line[LADDR_W-1:IDX_W];
    wr_st  = upd_we ? nxt_st : mesi_t'(fill_state);
  end

  assign wb_line = line_q;

  snp_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_arr (
    .clk(clk), .rd_en(accept), .rd_idx(snp_line[IDX_W-1:0]),
    .rd_tag(rd_tag), .rd_st(rd_st),
    .we(we), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_st(wr_st)
  );

  snp_eval #(.LADDR_W(LADDR_W), .IDX_W(IDX_W)) u_eval (
    .line_q(line_q), .par_q(par_q), .inv_q(inv_q),
    .rd_tag(rd_tag), .rd_st(rd_st),
    .par_err(lk_perr), .hit(lk_hit), .modified(lk_mod), .nxt_st(nxt_st)
  );

  snp_seq #(.BEATS(BEATS), .AH_DELAY(AH_DELAY)) u_seq (
    .clk(clk), .rst(rst), .strobe(snp_strobe), .mode(mode_q),
    .bus_held(bus_held), .burst_rdy(burst_rdy),
    .hit(lk_hit), .modified(lk_mod), .par_err(lk_perr),
    .accept(accept), .upd_we(upd_we),
    .hit_o(hit), .hitm_o(hitm), .apchk_o(apchk),
    .wb_active(wb_active), .wb_beat(wb_beat)
  );

  assert_oe_follow_R12: assert property (@(posedge clk) disable iff (rst)
    addr_hold |=> !addr_oe);
  assert_oe_release_R12: assert property (@(posedge clk) disable iff (rst)
    !addr_hold |=> addr_oe);
endmodule

// File: tb/sim_snoop_responder.sv
module sim_snoop_responder;
  localparam int LW = 27;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic snp_strobe = 0, snp_par = 0, snp_inv = 0, bus_held = 0;
  logic addr_hold = 0, burst_rdy = 0, fill_we = 0;
  logic [LW-1:0] snp_line = '0, fill_line = '0;
  logic [1:0] acq_mode = 2'b00, fill_state = 2'b00;
  logic hit, hitm, apchk, wb_active, addr_oe;
  logic [LW-1:0] wb_line;
  logic [1:0] wb_beat;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int exp_cyc[$];
  logic [2:0] exp_val[$];
  logic [23:0] m_tag [8];
  logic [1:0]  m_st [8];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  snoop_responder u0 (
    .clk(clk), .rst(rst), .snp_strobe(snp_strobe), .snp_line(snp_line),
    .snp_par(snp_par), .snp_inv(snp_inv), .acq_mode(acq_mode),
    .bus_held(bus_held), .addr_hold(addr_hold), .burst_rdy(burst_rdy),
    .fill_we(fill_we), .fill_line(fill_line), .fill_state(fill_state),
    .hit(hit), .hitm(hitm), .apchk(apchk), .wb_active(wb_active),
    .wb_line(wb_line), .wb_beat(wb_beat), .addr_oe(addr_oe)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [LW-1:0] mk(logic [23:0] t, int idx);
    return {t, 3'(idx)};
  endfunction

  task automatic set_snoop(logic [LW-1:0] ln, logic inv, logic [1:0] md, logic bad);
    snp_strobe = 1'b1;
    snp_line   = ln;
    snp_par    = (^ln) ^ bad;
    snp_inv    = inv;
    acq_mode   = md;
  endtask

  // driver: pushes the expected response computed from the line-state model
  task automatic snoop(logic [LW-1:0] ln, logic inv, logic [1:0] md, logic bad);
    int idx = int'(ln[2:0]);
    logic h = !bad && (m_tag[idx] == ln[26:3]) && (m_st[idx] != 2'b00);
    logic hm = h && (m_st[idx] == 2'b11);
    set_snoop(ln, inv, md, bad);
    exp_cyc.push_back(cyc + 2);
    exp_val.push_back({h, hm, bad});
    if (h) m_st[idx] = inv ? 2'b00 : 2'b01;
    tick(1);
    snp_strobe = 1'b0;
  endtask

  task automatic stray(logic [LW-1:0] ln, logic inv);
    set_snoop(ln, inv, 2'b00, 1'b0);
    tick(1);
    snp_strobe = 1'b0;
  endtask

  task automatic fill(int idx, logic [23:0] t, logic [1:0] s);
    fill_we = 1'b1; fill_line = mk(t, idx); fill_state = s;
    m_tag[idx] = t; m_st[idx] = s;
    tick(1);
    fill_we = 1'b0;
  endtask

  // monitor: pops expected responses at their cycle; flags responses nobody asked for
  always @(negedge clk) begin
    if (!rst) begin
      if (exp_cyc.size() > 0 && exp_cyc[0] == cyc) begin
        chk("R2 hit", {31'b0, hit}, {31'b0, exp_val[0][2]});
        chk("R6 hitm", {31'b0, hitm}, {31'b0, exp_val[0][1]});
        chk("R11 apchk", {31'b0, apchk}, {31'b0, exp_val[0][0]});
        void'(exp_cyc.pop_front());
        void'(exp_val.pop_front());
      end else if (hit || apchk) begin
        chk("R9 unrequested response", {30'b0, hit, apchk}, 32'h0);
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    tick(4);
    rst = 1'b0;
    tick(1);
    chk("R1 hit", {31'b0, hit}, 0);
    chk("R1 hitm", {31'b0, hitm}, 0);
    chk("R1 apchk", {31'b0, apchk}, 0);
    chk("R1 wb_active", {31'b0, wb_active}, 0);
    chk("R1 addr_oe", {31'b0, addr_oe}, 1);

    // R13: install all lines; states I S E M M M E S
    fill(0, 24'hA00000, 2'b00);
    fill(1, 24'hA00001, 2'b01);
    fill(2, 24'hA00002, 2'b10);
    fill(3, 24'hA00003, 2'b11);
    fill(4, 24'hA00004, 2'b11);
    fill(5, 24'hA00005, 2'b11);
    fill(6, 24'hA00006, 2'b10);
    fill(7, 24'hA00007, 2'b01);
    tick(1);

    // R3: tag mismatch and invalid entry miss
    snoop(mk(24'h0BEEF1, 1), 1'b1, 2'b00, 1'b0); tick(3);
    snoop(mk(24'hA00000, 0), 1'b0, 2'b00, 1'b0); tick(3);
    snoop(mk(24'hA00001, 1), 1'b0, 2'b00, 1'b0); tick(3); // R3 mismatch left S intact
    // R4: exclusive to shared, still hits
    snoop(mk(24'hA00002, 2), 1'b0, 2'b00, 1'b0); tick(3);
    snoop(mk(24'hA00002, 2), 1'b0, 2'b00, 1'b0); tick(3);
    // R5: shared invalidated, then misses
    snoop(mk(24'hA00001, 1), 1'b1, 2'b00, 1'b0); tick(3);
    snoop(mk(24'hA00001, 1), 1'b0, 2'b00, 1'b0); tick(3);

    // R9: strobe during the lookup cycle is dropped and does not invalidate line 7
    snoop(mk(24'hA00006, 6), 1'b0, 2'b00, 1'b0);
    stray(mk(24'hA00007, 7), 1'b1);
    tick(4);
    snoop(mk(24'hA00007, 7), 1'b0, 2'b00, 1'b0); tick(3);

    // R11: bad parity on a modified line: apchk only, no writeback, state kept
    snoop(mk(24'hA00003, 3), 1'b1, 2'b00, 1'b1);
    tick(5);
    chk("R11 no writeback", {31'b0, wb_active}, 0);
    chk("R11 no hitm", {31'b0, hitm}, 0);

    // R7/R6/R9/R10: address-hold writeback of line 3 (still modified)
    snoop(mk(24'hA00003, 3), 1'b0, 2'b00, 1'b0);   // now at s+1
    bus_held = 1'b1;                                 // must not matter under address-hold
    tick(1);                                         // s+2
    chk("R6 hitm raised", {31'b0, hitm}, 1);
    stray(mk(24'hA00002, 2), 1'b1);                  // R9 strobe in wait window; at s+3
    chk("R7 not yet", {31'b0, wb_active}, 0);
    tick(1);                                         // s+4
    chk("R7 launch", {31'b0, wb_active}, 1);
    chk("R6 wb_line", 32'(wb_line), 32'(mk(24'hA00003, 3)));
    chk("R6 beat0", {30'b0, wb_beat}, 0);
    burst_rdy = 1'b1;
    tick(1);                                         // s+5
    burst_rdy = 1'b0;
    chk("R6 beat1", {30'b0, wb_beat}, 1);
    tick(1);                                         // s+6
    chk("R6 beat held", {30'b0, wb_beat}, 1);
    burst_rdy = 1'b1;
    tick(2);                                         // s+8
    chk("R6 beat3", {30'b0, wb_beat}, 3);
    chk("R6 hitm held", {31'b0, hitm}, 1);
    // R10: new strobe together with the final burst-ready (line 2 is shared)
    set_snoop(mk(24'hA00002, 2), 1'b0, 2'b00, 1'b0);
    exp_cyc.push_back(cyc + 2);
    exp_val.push_back(3'b100);
    tick(1);                                         // s+9
    snp_strobe = 1'b0; burst_rdy = 1'b0; bus_held = 1'b0;
    chk("R6 wb done", {31'b0, wb_active}, 0);
    chk("R6 hitm dropped", {31'b0, hitm}, 0);
    m_st[3] = 2'b01;
    tick(3);
    snoop(mk(24'hA00003, 3), 1'b0, 2'b00, 1'b0); tick(3); // R4 modified -> shared

    // R8/R5: back-off, invalidate modified line 4
    bus_held = 1'b1;
    snoop(mk(24'hA00004, 4), 1'b1, 2'b01, 1'b0);   // s+1
    tick(3);                                         // s+4
    chk("R8 held off", {31'b0, wb_active}, 0);
    bus_held = 1'b0;
    tick(1);                                         // s+5
    chk("R8 launch after release", {31'b0, wb_active}, 1);
    burst_rdy = 1'b1;
    tick(4);
    burst_rdy = 1'b0;
    chk("R5 wb done", {31'b0, wb_active}, 0);
    tick(2);
    snoop(mk(24'hA00004, 4), 1'b0, 2'b00, 1'b0); tick(3); // R5 now invalid

    // R8: bus-hold with acknowledge already low
    snoop(mk(24'hA00005, 5), 1'b0, 2'b10, 1'b0);   // s+1
    tick(2);                                         // s+3
    chk("R8 hold launch", {31'b0, wb_active}, 1);
    burst_rdy = 1'b1;
    tick(4);
    burst_rdy = 1'b0;
    chk("R8 wb done", {31'b0, wb_active}, 0);
    tick(2);

    // R12: address bus release follows address-hold by one clock
    addr_hold = 1'b1;
    chk("R12 still driving", {31'b0, addr_oe}, 1);
    tick(1);
    chk("R12 released", {31'b0, addr_oe}, 0);
    addr_hold = 1'b0;
    tick(1);
    chk("R12 driving again", {31'b0, addr_oe}, 1);

    // R13: refill entry 6 with a new tag
    fill(6, 24'h5A5A5A, 2'b10);
    snoop(mk(24'hA00006, 6), 1'b0, 2'b00, 1'b0); tick(3);
    snoop(mk(24'h5A5A5A, 6), 1'b0, 2'b00, 1'b0); tick(3);

    tick(4);
    chk("R2 scoreboard drained", 32'(exp_cyc.size()), 0);
    finish_run();
  end
endmodule